// File: doc/BRIEF.md
# Segmented Reciprocal Divider

This block divides a signed 16-bit dividend by a signed 16-bit divisor, both in 1.15 fixed point. No iterative divider is used. The block takes the magnitude of the divisor and looks up an approximate positive reciprocal in a compressed table. It then multiplies that reciprocal by the magnitude of the dividend. The result sign is the exclusive-or of the two operand signs and is applied last.

The table is filled at elaboration by a function, so no contents are written out by hand. Small divisor magnitudes each get their own entry, because the reciprocal changes steeply there. Larger magnitudes share one entry among a group of neighbours, and the group grows from 1 to 4 to 16 to 32 as the curve flattens. Each entry holds the reciprocal of its group's centre divisor.

The block is a three-stage pipeline: address, table read, multiply. It accepts one operation per clock and delivers each result exactly three cycles after it is accepted. A zero divisor does not stall the pipeline. It returns a saturated quotient and raises a flag alongside the result.

Top module: `rdiv_lut`

## Requirements
- R1: A result appears with `out_valid` high exactly 3 clock cycles after `start` is sampled high. When `start` is sampled low, `out_valid` is low 3 cycles later.
- R2: Let m be the divisor magnitude. Values m < 2048 map one-to-one to addresses 0..2047. Values 2048 ≤ m < 6144 share one address per group of 4, at addresses 2048..3071. Values 6144 ≤ m < 12288 share one address per group of 16, at addresses 3072..3455. Values 12288 ≤ m ≤ 32767 share one address per group of 32, at addresses 3456..4095.
- R3: For a group starting at divisor s with size g, the table entry is the unsigned 26-bit, 16.10 value round(2^25 / d). Here d = s for g = 1 and d = s + g/2 otherwise, and rounding is half up via (2^25 + d/2) / d.
- R4: The quotient magnitude is (|a| × entry) >> 10. It is output as a 32-bit two's-complement value with 15 fraction bits.
- R5: The quotient is negated when exactly one operand is negative. A zero dividend gives a quotient of 0.
- R6: A zero divisor gives 0x7FFFFFFF for a non-negative dividend and 0x80000001 for a negative dividend. `out_div0` is high with that result and low with every other result.
- R7: A divisor of 0x8000 (−1.0) uses the entry for magnitude 32767, with negative sign.
- R8: While reset is held, `out_valid`, `out_div0` and `out_quot` are all zero.
- R9: Operations issued on consecutive cycles, with or without idle gaps, each produce their own independent result in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operands are valid this cycle |
| in_dividend | input | 16 | Signed 1.15 dividend |
| in_divisor | input | 16 | Signed 1.15 divisor |
| out_valid | output | 1 | Result valid |
| out_quot | output | 32 | Signed quotient, 15 fraction bits |
| out_div0 | output | 1 | Divisor was zero for this result |

## Verification
A wrong segment boundary or group shift makes the block read a neighbouring entry. That appears at the ports three cycles later as a quotient off by a few counts, but only for divisors on or near a segment edge. For this reason the divisors just below and at each boundary are driven with a full-scale dividend, which magnifies any entry error. A sign or saturation fault shows on the very first affected result. A pipeline misalignment between the valid bit and the data shows as a result attached to the wrong operation during back-to-back streams with gaps.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    // Divisor value at the centre of the group behind table index idx.
    function automatic int unsigned grp_centre(
        input int unsigned idx,
        input int unsigned b1, input int unsigned b2, input int unsigned b3,
        input int unsigned g1, input int unsigned g2, input int unsigned g3);
        int unsigned a2;
        int unsigned a3;
        a2 = b1 + (b2 - b1) / g1;
        a3 = a2 + (b3 - b2) / g2;
        if (idx < b1)      return idx;
        else if (idx < a2) return b1 + (idx - b1) * g1 + g1 / 2;
        else if (idx < a3) return b2 + (idx - a2) * g2 + g2 / 2;
        else               return b3 + (idx - a3) * g3 + g3 / 2;
    endfunction

    // Rounded reciprocal 2^one_sh / centre; all ones for the unused zero slot.
    function automatic logic [63:0] recip_entry(
        input int unsigned centre, input int unsigned one_sh, input int unsigned rw);
        if (centre == 0) return (64'd1 << rw) - 64'd1;
        return ((64'd1 << one_sh) + 64'(centre / 2)) / 64'(centre);
    endfunction

endpackage

// File: rtl/rdiv_seg_addr.sv
module rdiv_seg_addr #(
    parameter int MW = 15,
    parameter int AW = 12,
    parameter int B1 = 2048,
    parameter int B2 = 6144,
    parameter int B3 = 12288,
    parameter int G1 = 4,
    parameter int G2 = 16,
    parameter int G3 = 32
) (
    input  logic [MW-1:0] mag,
    output logic [AW-1:0] addr
);
    localparam int SH1   = $clog2(G1);
    localparam int SH2   = $clog2(G2);
    localparam int SH3   = $clog2(G3);
    localparam int A2    = B1 + (B2 - B1) / G1;
    localparam int A3    = A2 + (B3 - B2) / G2;
    localparam int DEPTH = A3 + ((1 << MW) - B3) / G3;

    int unsigned mv;
    int unsigned idx;

    always_comb begin
        mv = 32'(mag);
        if (mv < B1)      idx = mv;
        else if (mv < B2) idx = B1 + ((mv - B1) >> SH1);
        else if (mv < B3) idx = A2 + ((mv - B2) >> SH2);
        else              idx = A3 + ((mv - B3) >> SH3);
        addr = AW'(idx);
        // R2
        addr_range_chk: assert (idx < DEPTH);
    end
endmodule

// File: rtl/rdiv_recip_rom.sv
module rdiv_recip_rom #(
    parameter int MW     = 15,
    parameter int AW     = 12,
    parameter int RW     = 26,
    parameter int ONE_SH = 25,
    parameter int B1     = 2048,
    parameter int B2     = 6144,
    parameter int B3     = 12288,
    parameter int G1     = 4,
    parameter int G2     = 16,
    parameter int G3     = 32
) (
    input  logic [AW-1:0] addr,
    output logic [RW-1:0] recip
);
    localparam int A2    = B1 + (B2 - B1) / G1;
    localparam int A3    = A2 + (B3 - B2) / G2;
    localparam int DEPTH = A3 + ((1 << MW) - B3) / G3;

    logic [RW-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam int unsigned CEN = rdiv_pkg::grp_centre(i, B1, B2, B3, G1, G2, G3);
        localparam logic [63:0] ENT = rdiv_pkg::recip_entry(CEN, ONE_SH, RW);
        assign tbl[i] = ENT[RW-1:0];
    end

    always_comb begin
        if (32'(addr) < DEPTH) recip = tbl[addr];
        else                   recip = '0;
        // R3
        entry_nonzero_chk: assert (addr == '0 || recip != '0);
    end
endmodule

// File: rtl/rdiv_lut.sv
module rdiv_lut #(
    parameter int DW     = 16,
    parameter int RW     = 26,
    parameter int FRAC_R = 10,
    parameter int QW     = 32,
    parameter int B1     = 2048,
    parameter int B2     = 6144,
    parameter int B3     = 12288,
    parameter int G1     = 4,
    parameter int G2     = 16,
    parameter int G3     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [15:0]   in_dividend,
    input  logic [15:0]   in_divisor,
    output logic          out_valid,
    output logic [31:0]   out_quot,
    output logic          out_div0
);
    localparam int MW     = DW - 1;
    localparam int A2     = B1 + (B2 - B1) / G1;
    localparam int A3     = A2 + (B3 - B2) / G2;
    localparam int DEPTH  = A3 + ((1 << MW) - B3) / G3;
    localparam int AW     = $clog2(DEPTH);
    localparam int ONE_SH = MW + FRAC_R;
    localparam int PW     = DW + RW;
    localparam logic [QW-1:0] QPOS = {1'b0, {(QW-1){1'b1}}};
    localparam logic [QW-1:0] QNEG = ~QPOS + 1'b1;

    typedef struct packed {
        logic          vld;
        logic          neg;
        logic          z;
        logic [DW-1:0] amag;
        logic [AW-1:0] addr;
    } st1_t;

    typedef struct packed {
        logic          vld;
        logic          neg;
        logic          z;
        logic [DW-1:0] amag;
        logic [RW-1:0] recip;
    } st2_t;

    typedef struct packed {
        logic          vld;
        logic          z;
        logic [QW-1:0] quot;
    } st3_t;

    typedef struct packed {
        st1_t s1;
        st2_t s2;
        st3_t s3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [DW-1:0] a_mag, b_mag;
    logic [MW-1:0] b_clamp;
    logic [AW-1:0] seg_addr;
    logic [RW-1:0] rom_val;
    logic [PW-1:0] prod;
    logic [QW-1:0] qmag;

    always_comb begin
        a_mag   = in_dividend[DW-1] ? DW'(-in_dividend) : in_dividend;
        b_mag   = in_divisor[DW-1]  ? DW'(-in_divisor)  : in_divisor;
        b_clamp = b_mag[DW-1] ? {MW{1'b1}} : b_mag[MW-1:0];
    end

    rdiv_seg_addr #(
        .MW(MW), .AW(AW), .B1(B1), .B2(B2), .B3(B3), .G1(G1), .G2(G2), .G3(G3)
    ) u_seg (
        .mag  (b_clamp),
        .addr (seg_addr)
    );

    rdiv_recip_rom #(
        .MW(MW), .AW(AW), .RW(RW), .ONE_SH(ONE_SH),
        .B1(B1), .B2(B2), .B3(B3), .G1(G1), .G2(G2), .G3(G3)
    ) u_rom (
        .addr  (pipe_q.s1.addr),
        .recip (rom_val)
    );

    always_comb begin
        pipe_d = pipe_q;

        // address stage
        pipe_d.s1.vld  = start;
        pipe_d.s1.neg  = in_dividend[DW-1] ^ in_divisor[DW-1];
        pipe_d.s1.z    = (in_divisor == '0);
        pipe_d.s1.amag = a_mag;
        pipe_d.s1.addr = seg_addr;

        // table read stage
        pipe_d.s2.vld   = pipe_q.s1.vld;
        pipe_d.s2.neg   = pipe_q.s1.neg;
        pipe_d.s2.z     = pipe_q.s1.z;
        pipe_d.s2.amag  = pipe_q.s1.amag;
        pipe_d.s2.recip = rom_val;

        // multiply stage
        prod = PW'(pipe_q.s2.amag) * PW'(pipe_q.s2.recip);
        qmag = QW'(prod >> FRAC_R);
        pipe_d.s3.vld = pipe_q.s2.vld;
        pipe_d.s3.z   = pipe_q.s2.vld & pipe_q.s2.z;
        if (pipe_q.s2.vld) begin
            if (pipe_q.s2.z)        pipe_d.s3.quot = pipe_q.s2.neg ? QNEG : QPOS;
            else if (pipe_q.s2.neg) pipe_d.s3.quot = ~qmag + 1'b1;
            else                    pipe_d.s3.quot = qmag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.s3.vld;
    assign out_quot  = pipe_q.s3.quot;
    assign out_div0  = pipe_q.s3.z;

    // R1
    lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##3 out_valid);

    // R1
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> ##3 !out_valid);

    // R6
    div0_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_div0 |-> (out_valid && (out_quot == QPOS || out_quot == QNEG)));

    // R5
    sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && in_dividend != '0 && in_divisor != '0) |->
        ##3 (out_quot[QW-1] == $past(in_dividend[DW-1] ^ in_divisor[DW-1], 3)));
endmodule

// File: tb/rdiv_lut_tb.sv
`timescale 1ns/1ps
module rdiv_lut_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] in_dividend;
    logic [15:0] in_divisor;
    logic        out_valid;
    logic [31:0] out_quot;
    logic        out_div0;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    logic [15:0] op_a [64];
    logic [15:0] op_b [64];
    bit          op_v [64];
    string       op_t [64];
    int          n_ops;

    always #5 clk = ~clk;

    rdiv_lut u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .in_dividend (in_dividend),
        .in_divisor  (in_divisor),
        .out_valid   (out_valid),
        .out_quot    (out_quot),
        .out_div0    (out_div0)
    );

    function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b);
        longint ma, mb, s, g, d, e, mag;
        if (b == 16'd0) return a[15] ? 32'h8000_0001 : 32'h7FFF_FFFF;
        ma = a[15] ? 65536 - longint'(a) : longint'(a);
        mb = b[15] ? 65536 - longint'(b) : longint'(b);
        if (mb > 32767) mb = 32767;
        if (mb < 2048) begin
            g = 1; s = mb;
        end else if (mb < 6144) begin
            g = 4; s = 2048 + ((mb - 2048) / 4) * 4;
        end else if (mb < 12288) begin
            g = 16; s = 6144 + ((mb - 6144) / 16) * 16;
        end else begin
            g = 32; s = 12288 + ((mb - 12288) / 32) * 32;
        end
        d   = (g == 1) ? s : s + g / 2;
        e   = (33554432 + d / 2) / d;
        mag = (ma * e) / 1024;
        if (a[15] ^ b[15]) return 32'(-mag);
        return 32'(mag);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic add_op(input logic [15:0] a, input logic [15:0] b,
                          input bit v, input string tag);
        op_a[n_ops] = a; op_b[n_ops] = b; op_v[n_ops] = v; op_t[n_ops] = tag;
        n_ops++;
    endtask

    task automatic run_ops();
        logic [31:0] ex;
        for (int j = 0; j < n_ops + 3; j++) begin
            @(negedge clk);
            if (j < 3) begin
                // R1: leftover idle slots from before this run
                check(out_valid == 1'b0, "R1", "idle valid", 32'(out_valid), 32'd0);
            end else if (op_v[j-3]) begin
                ex = model(op_a[j-3], op_b[j-3]);
                check(out_valid == 1'b1 && out_quot == ex &&
                      out_div0 == (op_b[j-3] == 16'd0),
                      op_t[j-3], "quotient", out_quot, ex);
            end else begin
                // R1: gap produces no result
                check(out_valid == 1'b0, "R1", "gap valid", 32'(out_valid), 32'd0);
            end
            if (j < n_ops) begin
                start       = op_v[j];
                in_dividend = op_a[j];
                in_divisor  = op_b[j];
            end else begin
                start = 1'b0;
            end
        end
        n_ops = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        // R8
        check(out_valid == 1'b0 && out_div0 == 1'b0 && out_quot == 32'd0,
              "R8", "reset outputs", out_quot, 32'd0);
    endtask

    task automatic t_basic();
        // R4: plain positive ratios
        add_op(16'd16384, 16'd16384, 1, "R4");
        add_op(16'd8192,  16'd16384, 1, "R4");
        add_op(16'd32767, 16'd32767, 1, "R4");
        add_op(16'd100,   16'd3000,  1, "R4");
        run_ops();
    endtask

    task automatic t_signs();
        // R5: all sign combinations and a zero dividend
        add_op(16'd12000, 16'd20000, 1, "R5");
        add_op(16'hD120,  16'd20000, 1, "R5");
        add_op(16'd12000, 16'hB1E0,  1, "R5");
        add_op(16'hD120,  16'hB1E0,  1, "R5");
        add_op(16'h8000,  16'd1000,  1, "R5");
        add_op(16'd0,     16'hF000,  1, "R5");
        run_ops();
    endtask

    task automatic t_segments();
        // R2/R3: both sides of every segment edge, full-scale dividend
        add_op(16'd32767, 16'd1,     1, "R3");
        add_op(16'd32767, 16'd2047,  1, "R2");
        add_op(16'd32767, 16'd2048,  1, "R2");
        add_op(16'd32767, 16'd2051,  1, "R3");
        add_op(16'd32767, 16'd6143,  1, "R2");
        add_op(16'd32767, 16'd6144,  1, "R2");
        add_op(16'd32767, 16'd12287, 1, "R2");
        add_op(16'd32767, 16'd12288, 1, "R2");
        add_op(16'd32767, 16'd12319, 1, "R3");
        add_op(16'd1,     16'd32767, 1, "R3");
        run_ops();
    endtask

    task automatic t_div0();
        // R6
        add_op(16'd5000, 16'd0, 1, "R6");
        add_op(16'hF000, 16'd0, 1, "R6");
        add_op(16'd0,    16'd0, 1, "R6");
        add_op(16'd5000, 16'd7, 1, "R6");
        run_ops();
    endtask

    task automatic t_minus_one();
        // R7
        add_op(16'd16384, 16'h8000, 1, "R7");
        add_op(16'h8000,  16'h8000, 1, "R7");
        add_op(16'd16384, 16'd32767, 1, "R7");
        run_ops();
    endtask

    task automatic t_stream();
        logic [31:0] x;
        x = 32'h1234_5678;
        // R9: back-to-back with gaps every fifth slot
        for (int i = 0; i < 40; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            add_op(x[31:16], x[15:0], (i % 5) != 4, "R9");
        end
        run_ops();
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; in_dividend = '0; in_divisor = '0; n_ops = 0;
        repeat (3) @(posedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_signs();
        t_segments();
        t_div0();
        t_minus_one();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule